// File: doc/BRIEF.md
# Stereo DAC Zero-Data Detector

This block watches the stereo sample stream on its way into a DAC. Once per frame a strobe marks a new pair of 16-bit words, one for each channel. The block counts how many strobed frames in a row carried zero on both channels at once. When that run reaches a threshold (8192 frames by default), it raises a single flag. Other logic can use the flag to act on a silent input stream.

Any frame in which either channel is nonzero ends the run at once. The flag drops, and the count starts again from zero. While the DAC is powered down, the flag is forced low and the count is cleared. After power-down is released, a complete new run is needed before the flag can rise again. Sample values present when no strobe is asserted play no part in the decision.

Top module: `dac_zero_detect`

## Requirements
- R1: After rst_ni is asserted low, zero_flag_o is 0, and a full run of ZERO_FRAMES zero frames is needed before it can rise.
- R2: A zero frame is a rising clock edge with frame_i=1, left_i=0 and right_i=0 (all 16 bits zero). zero_flag_o goes to 1 in the cycle after the edge that samples the ZERO_FRAMES-th consecutive zero frame. After ZERO_FRAMES-1 zero frames it is still 0.
- R3: A strobed frame with one channel zero and the other nonzero does not count as a zero frame. It restarts the run, so ZERO_FRAMES further zero frames are needed after it.
- R4: A strobed frame with any nonzero bit on either channel clears zero_flag_o in the cycle after the edge that samples it.
- R5: The run count saturates at ZERO_FRAMES. zero_flag_o stays 1 through any number of further zero frames and does not wrap.
- R6: While dac_pd_i=1, zero_flag_o is 0 in that same cycle, with no clock edge needed. The run count is cleared, and after dac_pd_i returns to 0 a full run of ZERO_FRAMES zero frames is needed again.
- R7: On edges with frame_i=0, left_i and right_i are ignored, and neither the run count nor zero_flag_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | One-cycle strobe marking a valid sample pair |
| left_i | input | 16 | Left channel sample |
| right_i | input | 16 | Right channel sample |
| dac_pd_i | input | 1 | DAC power-down; forces the flag low and clears the run |
| zero_flag_o | output | 1 | High after a long run of all-zero stereo frames |

## Verification
The bench drives an unbroken run of zero frames and checks the flag one frame before the threshold and at the threshold. This pins down the exact run length. Further zero frames past the threshold check that the count saturates and does not wrap. Frames with only one channel nonzero, and a single nonzero bit at the end of a long run, separate a both-channels test from an either-channel test and show that the run truly restarts. A power-down pulse in the middle of a run, and a run in which nonzero data fills the idle cycles between strobes, show that power-down clears the count and that unstrobed data is ignored.

// File: rtl/dac_zd_pkg.sv
package dac_zd_pkg;
  typedef enum logic [1:0] {
    FRAME_NONE = 2'd0,
    FRAME_ZERO = 2'd1,
    FRAME_DATA = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/dac_zd_frame_qual.sv
module dac_zd_frame_qual
  import dac_zd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 2
) (
  input  logic                          frame_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0] sample_i,
  output frame_kind_e                   kind_o
);
  logic [NUM_CH-1:0] ch_zero;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_zero[c] = (sample_i[c] == '0);
  end

  always_comb begin
    if (!frame_i)      kind_o = FRAME_NONE;
    else if (&ch_zero) kind_o = FRAME_ZERO;
    else               kind_o = FRAME_DATA;
  end
endmodule

// File: rtl/dac_zd_run_counter.sv
module dac_zd_run_counter
  import dac_zd_pkg::*;
#(
  parameter int unsigned LIMIT = 8192,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  frame_kind_e      kind_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             near_o
);
  localparam logic [CNT_W-1:0] LimV = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      unique case (kind_i)
        FRAME_ZERO: if (cnt_q != LimV) cnt_q <= cnt_q + 1'b1;
        FRAME_DATA: cnt_q <= '0;
        default:    ;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  // next zero frame completes (or extends) a full run
  assign near_o = (cnt_q >= LimV - 1'b1);

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LimV);

  assert_data_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FRAME_DATA) |=> (cnt_q == '0));
endmodule

// File: rtl/dac_zero_detect.sv
module dac_zero_detect
  import dac_zd_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ZERO_FRAMES = 8192,
  localparam int unsigned CNT_W      = $clog2(ZERO_FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic              dac_pd_i,
  output logic              zero_flag_o
);
  localparam logic [CNT_W-1:0] LimV = CNT_W'(ZERO_FRAMES);

  frame_kind_e              kind;
  logic [1:0][DATA_W-1:0]   samples;
  logic [CNT_W-1:0]         run_cnt;
  logic                     run_near;
  logic                     flag_q;

  assign samples = {right_i, left_i};

  dac_zd_frame_qual #(.DATA_W(DATA_W), .NUM_CH(2)) u_qual (
    .frame_i  (frame_i),
    .sample_i (samples),
    .kind_o   (kind)
  );

  dac_zd_run_counter #(.LIMIT(ZERO_FRAMES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dac_pd_i),
    .kind_i (kind),
    .cnt_o  (run_cnt),
    .near_o (run_near)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (dac_pd_i) begin
      flag_q <= 1'b0;
    end else begin
      unique case (kind)
        FRAME_ZERO: if (run_near) flag_q <= 1'b1;
        FRAME_DATA: flag_q <= 1'b0;
        default:    ;
      endcase
    end
  end

  // power-down gates the output without waiting for an edge
  assign zero_flag_o = flag_q & ~dac_pd_i;

  assert_flag_implies_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> (run_cnt == LimV));

  assert_rise_at_limit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (run_cnt == LimV));

  assert_nonzero_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !dac_pd_i && ((left_i != '0) || (right_i != '0))) |=> !flag_q);

  assert_pd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_pd_i |=> (run_cnt == '0) && !flag_q);

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !dac_pd_i) |=> $stable(run_cnt) && $stable(flag_q));
endmodule

// File: tb/dac_zero_detect_test.sv
module dac_zero_detect_test;
  localparam int unsigned N = 8192;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_i = 1'b0;
  logic [15:0] left_i = '0;
  logic [15:0] right_i = '0;
  logic        dac_pd_i = 1'b0;
  logic        zero_flag_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dac_zero_detect #(.DATA_W(16), .ZERO_FRAMES(N)) uut (
    .clk_i, .rst_ni, .frame_i, .left_i, .right_i, .dac_pd_i, .zero_flag_o
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: zero_flag_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one strobed frame; returns after the sampling edge has passed
  task automatic send_frame(input logic [15:0] l, input logic [15:0] r);
    frame_i = 1'b1; left_i = l; right_i = r;
    @(negedge clk_i);
    frame_i = 1'b0; left_i = '0; right_i = '0;
  endtask

  task automatic zero_frames(input int n);
    for (int i = 0; i < n; i++) send_frame('0, '0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; frame_i = 1'b0; dac_pd_i = 1'b0; left_i = '0; right_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset_R1();
    do_reset();
    check("R1 reset", zero_flag_o, 1'b0);
    zero_frames(N - 1);
    check("R1 no early rise after reset", zero_flag_o, 1'b0);
  endtask

  task automatic t_threshold_R2();
    do_reset();
    zero_frames(N - 1);
    check("R2 low at N-1", zero_flag_o, 1'b0);
    send_frame('0, '0);
    check("R2 high at N", zero_flag_o, 1'b1);
  endtask

  task automatic t_saturate_R5();
    zero_frames(300);
    check("R5 stays high past threshold", zero_flag_o, 1'b1);
    repeat (5) @(negedge clk_i);
    check("R5 still high when idle", zero_flag_o, 1'b1);
  endtask

  task automatic t_drop_R4();
    send_frame(16'h0000, 16'h8000);
    check("R4 drop on right msb", zero_flag_o, 1'b0);
    zero_frames(N - 1);
    check("R4 restart low at N-1", zero_flag_o, 1'b0);
    send_frame('0, '0);
    check("R4 restart high at N", zero_flag_o, 1'b1);
    send_frame(16'h0001, 16'h0000);
    check("R4 drop on left lsb", zero_flag_o, 1'b0);
  endtask

  task automatic t_one_channel_R3();
    do_reset();
    zero_frames(100);
    send_frame(16'h0000, 16'h1234);
    zero_frames(200);
    send_frame(16'hFFFF, 16'h0000);
    zero_frames(N - 1);
    check("R3 one-channel frame restarted run", zero_flag_o, 1'b0);
    send_frame('0, '0);
    check("R3 full run after one-channel frame", zero_flag_o, 1'b1);
  endtask

  task automatic t_powerdown_R6();
    check("R6 precondition high", zero_flag_o, 1'b1);
    dac_pd_i = 1'b1;
    #1;
    check("R6 low same cycle", zero_flag_o, 1'b0);
    @(negedge clk_i);
    send_frame('0, '0);
    check("R6 low with zeros during pd", zero_flag_o, 1'b0);
    dac_pd_i = 1'b0;
    @(negedge clk_i);
    check("R6 low after release", zero_flag_o, 1'b0);
    zero_frames(N - 1);
    check("R6 low at N-1 after release", zero_flag_o, 1'b0);
    send_frame('0, '0);
    check("R6 high at N after release", zero_flag_o, 1'b1);
  endtask

  task automatic t_idle_ignored_R7();
    do_reset();
    for (int i = 0; i < N; i++) begin
      send_frame('0, '0);
      left_i = 16'(i * 37 + 1); right_i = 16'hA5A5;
      @(negedge clk_i);
      left_i = '0; right_i = '0;
      if (i == N - 2) check("R7 low at N-1 with idle data", zero_flag_o, 1'b0);
    end
    check("R7 high at N despite idle data", zero_flag_o, 1'b1);
    left_i = 16'h7FFF; right_i = 16'h7FFF;
    repeat (3) @(negedge clk_i);
    check("R7 idle nonzero does not clear", zero_flag_o, 1'b1);
    left_i = '0; right_i = '0;
  endtask

  initial begin
    t_reset_R1();
    t_threshold_R2();
    t_saturate_R5();
    t_drop_R4();
    t_one_channel_R3();
    t_powerdown_R6();
    t_idle_ignored_R7();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule